// File: doc/BRIEF.md
# Stepped Seven-Segment Digit Scanner

This block drives a seven-segment display of several digits whose segment lines are shared by all digits. Only one digit enable is active at any moment, and the segment lines carry the pattern of that digit's own BCD code. Over time, every digit is shown in turn.

The scan does not run from an internal refresh counter. It moves one position for each pulse on a step input. A single-cycle pulse from a pushbutton lets the multiplexing be watched one digit at a time. A periodic refresh tick from a surrounding design turns the same block into an ordinary scanning driver.

A single-code mode shows the lowest code field on every position. In both modes the same decoder serves all digits. Button debouncing and the refresh-rate divider are outside this block.

Top module: `seg_scan_mux`

## Requirements
- R1: While `rst_n` is low, `an_n` is all ones, `seg_n` is 7'h7F and `dot_n` is 1. Reset selects position 0, the rightmost digit. From the first clock edge after release, `an_n` is 4'b1110.
- R2: On each clock edge where `step` is high, the active position moves by one, from rightmost toward leftmost. Position k is shown by driving `an_n[k]` low.
- R3: A step taken at the leftmost position (k = NDIG-1) returns the scan to position 0.
- R4: On a clock edge where `step` is low, the active position does not change.
- R5: After the first clock edge since reset, exactly one bit of `an_n` is low.
- R6: Position k shows the code held in `digits_in[4k+3:4k]`, so bits 15:12 go to the leftmost digit and bits 3:0 go to the rightmost digit.
- R7: Codes 0 to 9 drive the standard digit shapes on `seg_n` = {g,f,e,d,c,b,a}, active low. For example, 0 gives 7'h40, 1 gives 7'h79 and 8 gives 7'h00.
- R8: Codes 10 to 15 blank the digit, giving `seg_n` = 7'h7F.
- R9: `dot_n` is low exactly when `dot_en[k]` is high for the active position k.
- R10: While `single_mode` is high, every position shows the code in `digits_in[3:0]`.
- R11: All outputs are registered. A change on any input appears on the outputs at the next clock edge, and the enable and segment lines of a new position change on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step | input | 1 | Advance the scan by one position on this edge |
| single_mode | input | 1 | Show the code in bits 3:0 on every position |
| digits_in | input | 4*NDIG | Packed BCD codes, 4 bits per position |
| dot_en | input | NDIG | Dot request for each position |
| seg_n | output | 7 | Segments {g,f,e,d,c,b,a}, active low |
| dot_n | output | 1 | Dot segment, active low |
| an_n | output | NDIG | Digit enables, active low, one-hot |

## Verification
The bench builds the block with its default of four positions. With that size, a full walk of the positions and the wrap back to the rightmost digit take only four steps, so each scan order case can be checked exhaustively. In single-code mode, the bench steps through all sixteen code values, which covers both the digit shapes and the blanked codes while the position keeps moving.

// File: rtl/seg_scan_mux.sv
module seg_scan_mux #(
  parameter int NDIG = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              single_mode,
  input  logic [4*NDIG-1:0] digits_in,
  input  logic [NDIG-1:0]   dot_en,
  output logic [6:0]        seg_n,
  output logic              dot_n,
  output logic [NDIG-1:0]   an_n
);
  localparam int PW = (NDIG > 1) ? $clog2(NDIG) : 1;
  localparam logic [PW-1:0] LAST = PW'(NDIG - 1);

  logic [PW-1:0]   pos, pos_nx;
  logic [NDIG-1:0] en_nx;
  logic [3:0]      code;
  logic [6:0]      lit;

  assign pos_nx = !step ? pos : (pos == LAST) ? '0 : pos + 1'b1;

  always_comb begin
    code = digits_in[3:0];
    for (int k = 1; k < NDIG; k++)
      if (!single_mode && pos_nx == PW'(k)) code = digits_in[4*k +: 4];
  end

  generate
    for (genvar k = 0; k < NDIG; k++) begin : g_en
      assign en_nx[k] = (pos_nx == PW'(k));
    end
  endgenerate

  always_comb begin
    case (code)
      4'd0: lit = 7'b0111111;
      4'd1: lit = 7'b0000110;
      4'd2: lit = 7'b1011011;
      4'd3: lit = 7'b1001111;
      4'd4: lit = 7'b1100110;
      4'd5: lit = 7'b1101101;
      4'd6: lit = 7'b1111101;
      4'd7: lit = 7'b0000111;
      4'd8: lit = 7'b1111111;
      4'd9: lit = 7'b1101111;
      default: lit = 7'b0000000;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos   <= '0;
      seg_n <= '1;
      dot_n <= 1'b1;
      an_n  <= '1;
    end else begin
      pos   <= pos_nx;
      seg_n <= ~lit;
      dot_n <= ~|(dot_en & en_nx);
      an_n  <= ~en_nx;
    end
  end
endmodule

module seg_scan_mux_chk #(
  parameter int NDIG = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              step,
  input logic              single_mode,
  input logic [4*NDIG-1:0] digits_in,
  input logic [NDIG-1:0]   dot_en,
  input logic [6:0]        seg_n,
  input logic              dot_n,
  input logic [NDIG-1:0]   an_n
);
  logic started;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) started <= 1'b0;
    else        started <= 1'b1;

  // R5
  one_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> $onehot(~an_n));

  // R4
  hold_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !step) |=> $stable(an_n));

  // R2
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (started && step) |=> (an_n == {$past(an_n[NDIG-2:0]), $past(an_n[NDIG-1])}));

  // R9
  dot_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    started |=> (dot_n == !(|($past(dot_en) & ~an_n))));

  // R8
  blank_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (started && single_mode && digits_in[3:0] > 4'd9) |=> (seg_n == 7'h7F));
endmodule

bind seg_scan_mux seg_scan_mux_chk #(.NDIG(NDIG)) u_chk (
  .clk(clk), .rst_n(rst_n), .step(step), .single_mode(single_mode),
  .digits_in(digits_in), .dot_en(dot_en), .seg_n(seg_n), .dot_n(dot_n),
  .an_n(an_n)
);

// File: tb/tb_seg_scan_mux.sv
module tb_seg_scan_mux;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step = 1'b0;
  logic        single_mode = 1'b0;
  logic [15:0] digits_in = 16'h4721;
  logic [3:0]  dot_en = 4'b0000;
  logic [6:0]  seg_n;
  logic        dot_n;
  logic [3:0]  an_n;

  int checks = 0;
  int errors = 0;
  int pos = 0;
  bit done = 0;

  seg_scan_mux #(.NDIG(4)) dut (.*);

  always #10 clk = ~clk;

  function automatic logic [6:0] shape(input logic [3:0] c);
    case (c)
      4'd0: return 7'h40;
      4'd1: return 7'h79;
      4'd2: return 7'h24;
      4'd3: return 7'h30;
      4'd4: return 7'h19;
      4'd5: return 7'h12;
      4'd6: return 7'h02;
      4'd7: return 7'h78;
      4'd8: return 7'h00;
      4'd9: return 7'h10;
      default: return 7'h7F;
    endcase
  endfunction

  task automatic expect_out(input string r, input logic [3:0] an_e,
                            input logic [6:0] seg_e, input logic dot_e);
    checks++;
    if (an_n !== an_e || seg_n !== seg_e || dot_n !== dot_e) begin
      errors++;
      $display("FAIL %s: an_n=%b seg_n=%h dot_n=%b expected an_n=%b seg_n=%h dot_n=%b",
               r, an_n, seg_n, dot_n, an_e, seg_e, dot_e);
    end
  endtask

  function automatic logic [3:0] en_of(input int p);
    return ~(4'b0001 << p);
  endfunction

  function automatic logic [6:0] seg_of(input int p);
    return shape(single_mode ? digits_in[3:0] : digits_in[4*p +: 4]);
  endfunction

  task automatic check_now(input string r);
    expect_out(r, en_of(pos), seg_of(pos), ~dot_en[pos]);
  endtask

  task automatic do_step();
    step = 1'b1;
    @(posedge clk);
    @(negedge clk);
    step = 1'b0;
    pos = (pos + 1) % 4;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    expect_out("R1 reset", 4'b1111, 7'h7F, 1'b1);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    pos = 0;
    expect_out("R1 first edge", 4'b1110, shape(4'h1), 1'b1);
  endtask

  task automatic t_walk();
    for (int i = 0; i < 3; i++) begin
      do_step();
      check_now("R2 R6 R7 walk");
    end
    do_step();
    check_now("R3 wrap");
  endtask

  task automatic t_hold();
    repeat (5) begin
      @(negedge clk);
      check_now("R4 hold");
    end
  endtask

  task automatic t_dot();
    dot_en = 4'b0100;
    @(negedge clk);
    check_now("R9 dot off");
    do_step();
    do_step();
    check_now("R9 dot on");
    dot_en = 4'b0000;
    @(negedge clk);
  endtask

  task automatic t_timing();
    logic [6:0] old_seg;
    old_seg = seg_n;
    digits_in = 16'h9999;
    #8;
    checks++;
    if (seg_n !== old_seg) begin
      errors++;
      $display("FAIL R11 early: seg_n=%h expected %h", seg_n, old_seg);
    end
    @(posedge clk);
    @(negedge clk);
    check_now("R11 after edge");
    digits_in = 16'h3850;
    do_step();
    check_now("R11 same edge");
  endtask

  task automatic t_single();
    single_mode = 1'b1;
    for (int c = 0; c < 16; c++) begin
      digits_in = {12'h888, 4'(c)};
      do_step();
      expect_out(c > 9 ? "R8 R10 blank" : "R7 R10 single", en_of(pos), shape(4'(c)), 1'b1);
    end
    single_mode = 1'b0;
  endtask

  task automatic t_invalid();
    digits_in = 16'hF5AB;
    for (int i = 0; i < 4; i++) begin
      do_step();
      check_now("R8 R6 mixed");
    end
  endtask

  initial begin
    t_reset();
    t_walk();
    t_hold();
    t_dot();
    t_timing();
    t_single();
    t_invalid();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule